// File: doc/BRIEF.md
# Delay-Ordered Column Compression Multiplier

This block multiplies two unsigned N-bit operands and returns the full 2N-bit product in a single combinational path. An AND array forms every partial-product bit. Each weight column is then compressed with full and half adders until exactly two bits per column remain. A carry-propagate adder sums those two rows.

The compression does not follow a fixed tree shape. Each signal in a column carries an estimated arrival time, counted in half-XOR units, and the column's pending signals are kept ordered by that estimate. Adders always take the earliest signals first. Inside a full adder, the latest of the three chosen signals is routed to the carry-in port, which is the faster path to the sum.

Every partial-product bit starts at time zero, so all of the ordering depends only on N. The wiring is fixed once the block is elaborated and does not depend on operand values. The block is used wherever a wide unsigned product is needed in one cycle, and the surrounding logic registers it.

Top module: `mdt_mult`

## Requirements
- R1: For every pair of operands, `prod_o` equals the unsigned product of `a_i` and `b_i` across all 2N bits.
- R2: If either operand is zero, `prod_o` is zero.
- R3: If one operand is 1, `prod_o` equals the other operand, zero-extended to 2N bits.
- R4: When both operands are all ones, `prod_o` equals 2^(2N) - 2^(N+1) + 1. For N=4 this is 0xE1, for N=8 0xFE01, for N=12 0xFFE001 and for N=16 0xFFFE0001.
- R5: The two lowest weight columns are not compressed. Product bit 0 equals a[0]&b[0], and product bit 1 equals (a[1]&b[0]) ^ (a[0]&b[1]).
- R6: Swapping the two operands leaves `prod_o` unchanged.
- R7: When `a_i` is 2^k, `prod_o` equals `b_i` shifted left by k.
- R8: The result is correct when the parameter N is 4, 8, 12 or 16.
- R9: With N=12, 0xB54 times 0xB1B gives 0x7DCDDC.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | N | Unsigned multiplicand |
| b_i | input | N | Unsigned multiplier |
| prod_o | output | 2N | Unsigned full-width product |

## Verification
The final carry of each column's last adder and the ripple carry of the final adder meet at the same weight in the same evaluation. The worst case is when every column is full and every adder carries.

All-ones operands produce this case at every width, because every column then generates carries along its whole compression chain while the final adder also propagates a carry. Power-of-two and swapped operands exercise the same positions with sparse columns.

Each result is judged against a product the bench computes in 64-bit arithmetic, on four instances of the block that run in parallel.

// File: rtl/mdt_pkg.sv
package mdt_pkg;
  // Path costs in half-XOR units
  localparam int FA_AB_TO_S = 4;
  localparam int FA_CI_TO_S = 2;
  localparam int FA_TO_C    = 2;
  localparam int HA_TO_S    = 2;
  localparam int HA_TO_C    = 1;

  function automatic int max2(input int x, input int y);
    return (x > y) ? x : y;
  endfunction
endpackage

// File: rtl/mdt_pp_array.sv
module mdt_pp_array #(
  parameter int N = 12
) (
  input  logic [N-1:0]        a_i,
  input  logic [N-1:0]        b_i,
  output logic [N-1:0][N-1:0] pp_o
);
  // Row j holds a_i gated by b_i[j]; bit k of row j has weight j+k
  for (genvar j = 0; j < N; j++) begin : g_row
    assign pp_o[j] = a_i & {N{b_i[j]}};
  end
endmodule

// File: rtl/mdt_col_tree.sv
module mdt_col_tree
  import mdt_pkg::*;
#(
  parameter int N = 12
) (
  input  logic [N-1:0][N-1:0] pp_i,
  output logic [2*N-1:0]      row_a_o,
  output logic [2*N-1:0]      row_b_o
);
  localparam int W   = 2 * N;
  localparam int CAP = 2 * N + 2;

  logic [CAP-1:0] sig [W];
  int             dly [W][CAP];
  int             cnt [W];
  logic [W-1:0]   tail_c;
  logic           x0, x1, x2, s_t, c_t, last;
  int             d0, d1, d2, ds_t, dc_t;

  // Delays depend only on N, so the ordering below folds to fixed wiring
  always_comb begin
    row_a_o = '0;
    row_b_o = '0;
    tail_c  = '0;
    x0 = 1'b0; x1 = 1'b0; x2 = 1'b0; s_t = 1'b0; c_t = 1'b0; last = 1'b0;
    d0 = 0; d1 = 0; d2 = 0; ds_t = 0; dc_t = 0;
    for (int c = 0; c < W; c++) begin
      cnt[c] = 0;
      sig[c] = '0;
      for (int q = 0; q < CAP; q++) dly[c][q] = 0;
    end
    for (int j = 0; j < N; j++)
      for (int k = 0; k < N; k++) begin
        sig[j+k][cnt[j+k]] = pp_i[j][k];
        cnt[j+k] = cnt[j+k] + 1;
      end

    for (int c = 0; c < W; c++) begin
      if (c < 2) begin
        row_a_o[c] = sig[c][0];
        row_b_o[c] = (cnt[c] > 1) ? sig[c][1] : 1'b0;
      end else begin
        // order incoming signals by arrival, earliest first
        for (int p = 0; p < CAP; p++)
          for (int q = 0; q < CAP - 1; q++)
            if (q + 1 < cnt[c] && dly[c][q] > dly[c][q+1]) begin
              x0 = sig[c][q]; sig[c][q] = sig[c][q+1]; sig[c][q+1] = x0;
              d0 = dly[c][q]; dly[c][q] = dly[c][q+1]; dly[c][q+1] = d0;
            end

        // even height: one half adder on the two earliest signals
        if (cnt[c] >= 2 && cnt[c] % 2 == 0) begin
          x0 = sig[c][0]; x1 = sig[c][1];
          d0 = dly[c][0]; d1 = dly[c][1];
          s_t  = x0 ^ x1;
          c_t  = x0 & x1;
          ds_t = max2(d0, d1) + HA_TO_S;
          dc_t = max2(d0, d1) + HA_TO_C;
          for (int q = 0; q < CAP - 2; q++) begin
            sig[c][q] = sig[c][q+2];
            dly[c][q] = dly[c][q+2];
          end
          cnt[c] = cnt[c] - 2;
          if (cnt[c] == 0) begin
            row_a_o[c] = s_t;
            if (c + 1 < W) tail_c[c+1] = c_t;
          end else begin
            sig[c][cnt[c]] = s_t;
            dly[c][cnt[c]] = ds_t;
            cnt[c] = cnt[c] + 1;
            for (int q = CAP - 1; q > 0; q--)
              if (q < cnt[c] && dly[c][q-1] > dly[c][q]) begin
                x0 = sig[c][q]; sig[c][q] = sig[c][q-1]; sig[c][q-1] = x0;
                d0 = dly[c][q]; dly[c][q] = dly[c][q-1]; dly[c][q-1] = d0;
              end
            if (c + 1 < W) begin
              sig[c+1][cnt[c+1]] = c_t;
              dly[c+1][cnt[c+1]] = dc_t;
              cnt[c+1] = cnt[c+1] + 1;
            end
          end
        end

        // full adders on the three earliest; the latest feeds carry-in
        for (int k = 0; k < CAP; k++) begin
          if (cnt[c] >= 3) begin
            last = (cnt[c] == 3);
            x0 = sig[c][0]; x1 = sig[c][1]; x2 = sig[c][2];
            d0 = dly[c][0]; d1 = dly[c][1]; d2 = dly[c][2];
            s_t  = x0 ^ x1 ^ x2;
            c_t  = (x0 & x1) | (x2 & (x0 ^ x1));
            ds_t = max2(max2(d0, d1) + FA_AB_TO_S, d2 + FA_CI_TO_S);
            dc_t = max2(max2(d0, d1), d2) + FA_TO_C;
            for (int q = 0; q < CAP - 3; q++) begin
              sig[c][q] = sig[c][q+3];
              dly[c][q] = dly[c][q+3];
            end
            cnt[c] = cnt[c] - 3;
            if (last) begin
              row_a_o[c] = s_t;
              if (c + 1 < W) tail_c[c+1] = c_t;
            end else begin
              sig[c][cnt[c]] = s_t;
              dly[c][cnt[c]] = ds_t;
              cnt[c] = cnt[c] + 1;
              for (int q = CAP - 1; q > 0; q--)
                if (q < cnt[c] && dly[c][q-1] > dly[c][q]) begin
                  x0 = sig[c][q]; sig[c][q] = sig[c][q-1]; sig[c][q-1] = x0;
                  d0 = dly[c][q]; dly[c][q] = dly[c][q-1]; dly[c][q-1] = d0;
                end
              if (c + 1 < W) begin
                sig[c+1][cnt[c+1]] = c_t;
                dly[c+1][cnt[c+1]] = dc_t;
                cnt[c+1] = cnt[c+1] + 1;
              end
            end
          end
        end

        if (cnt[c] == 1) row_a_o[c] = sig[c][0];
        row_b_o[c] = tail_c[c];
      end
    end
  end
endmodule

// File: rtl/mdt_cpa.sv
module mdt_cpa #(
  parameter int W = 24
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] sum_o
);
  logic [W-1:0] cy;

  assign cy[0] = 1'b0;
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign sum_o[i] = a_i[i] ^ b_i[i] ^ cy[i];
    if (i < W - 1) begin : g_cy
      assign cy[i+1] = (a_i[i] & b_i[i]) | (cy[i] & (a_i[i] ^ b_i[i]));
    end
  end
endmodule

// File: rtl/mdt_mult.sv
module mdt_mult #(
  parameter int N = 12
) (
  input  logic [N-1:0]   a_i,
  input  logic [N-1:0]   b_i,
  output logic [2*N-1:0] prod_o
);
  localparam int W = 2 * N;

  logic [N-1:0][N-1:0] pp;
  logic [W-1:0]        row_a;
  logic [W-1:0]        row_b;

  mdt_pp_array #(.N(N)) u_pp (
    .a_i  (a_i),
    .b_i  (b_i),
    .pp_o (pp)
  );

  mdt_col_tree #(.N(N)) u_tree (
    .pp_i    (pp),
    .row_a_o (row_a),
    .row_b_o (row_b)
  );

  mdt_cpa #(.W(W)) u_cpa (
    .a_i   (row_a),
    .b_i   (row_b),
    .sum_o (prod_o)
  );
endmodule

// File: rtl/mdt_mult_chk.sv
module mdt_mult_chk #(
  parameter int N = 12
) (
  input logic [N-1:0]   a_i,
  input logic [N-1:0]   b_i,
  input logic [2*N-1:0] prod_o,
  input logic [2*N-1:0] row_a_i,
  input logic [2*N-1:0] row_b_i
);
  localparam int W = 2 * N;

  logic [W-1:0] full;
  logic [W-1:0] rows;

  assign full = W'(a_i) * W'(b_i);
  assign rows = row_a_i + row_b_i;

  always_comb begin
    if (!$isunknown({a_i, b_i})) begin
      a_r1_product: assert (prod_o == full);
      // R1: the two compressed rows already carry the whole product
      a_r1_rows_sum: assert (rows == full);
      a_r2_zero: assert (!(a_i == '0 || b_i == '0) || prod_o == '0);
      a_r3_unit: assert (!(b_i == N'(1)) || prod_o == W'(a_i));
      a_r5_low_bits: assert (prod_o[1:0] ==
          {(a_i[1] & b_i[0]) ^ (a_i[0] & b_i[1]), a_i[0] & b_i[0]});
    end
  end
endmodule

bind mdt_mult mdt_mult_chk #(.N(N)) u_chk (
  .a_i     (a_i),
  .b_i     (b_i),
  .prod_o  (prod_o),
  .row_a_i (row_a),
  .row_b_i (row_b)
);

// File: tb/sim_mdt_mult.sv
module sim_mdt_mult;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic [3:0]  a4,  b4;
  logic [7:0]  p4;
  logic [7:0]  a8,  b8;
  logic [15:0] p8;
  logic [11:0] a12, b12;
  logic [23:0] p12;
  logic [15:0] a16, b16;
  logic [31:0] p16;

  int n_chk = 0;
  int n_err = 0;

  mdt_mult #(.N(12)) u0  (.a_i(a12), .b_i(b12), .prod_o(p12));
  mdt_mult #(.N(4))  u4  (.a_i(a4),  .b_i(b4),  .prod_o(p4));
  mdt_mult #(.N(8))  u8  (.a_i(a8),  .b_i(b8),  .prod_o(p8));
  mdt_mult #(.N(16)) u16 (.a_i(a16), .b_i(b16), .prod_o(p16));

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s got %h exp %h", req, got, exp);
    end
  endtask

  task automatic drive(input logic [15:0] ax, input logic [15:0] bx);
    @(negedge clk);
    a4 = ax[3:0];   b4 = bx[3:0];
    a8 = ax[7:0];   b8 = bx[7:0];
    a12 = ax[11:0]; b12 = bx[11:0];
    a16 = ax;       b16 = bx;
    #(CLK_PERIOD / 4);
  endtask

  task automatic check_all(input string req);
    chk({req, " N4"},  64'(p4),  64'(a4)  * 64'(b4));
    chk({req, " N8"},  64'(p8),  64'(a8)  * 64'(b8));
    chk({req, " N12"}, 64'(p12), 64'(a12) * 64'(b12));
    chk({req, " N16"}, 64'(p16), 64'(a16) * 64'(b16));
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_chk++;
    n_err++;
    $display("FAIL R1 watchdog got timeout exp completion");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [15:0] x, y;
    logic [23:0] s12;
    logic [31:0] s16;

    // R2: start from zero operands, then one side zero
    drive(16'h0000, 16'h0000);
    chk("R2 zero/zero", 64'(p16), 64'h0);
    check_all("R2");
    drive(16'h0000, 16'hBEEF);
    check_all("R2");
    chk("R2 a=0", 64'(p12), 64'h0);
    drive(16'h1234, 16'h0000);
    chk("R2 b=0", 64'(p16), 64'h0);

    // R3: unit operand
    drive(16'h0001, 16'hA5C3);
    chk("R3 a=1", 64'(p12), 64'(b12));
    chk("R3 a=1 N16", 64'(p16), 64'(b16));
    drive(16'h9E37, 16'h0001);
    chk("R3 b=1", 64'(p16), 64'(a16));
    chk("R3 b=1 N4", 64'(p4), 64'(a4));

    // R4: all-ones operands, every carry chain active
    drive(16'hFFFF, 16'hFFFF);
    chk("R4 N4",  64'(p4),  64'hE1);
    chk("R4 N8",  64'(p8),  64'hFE01);
    chk("R4 N12", 64'(p12), 64'hFFE001);
    chk("R4 N16", 64'(p16), 64'hFFFE0001);

    // R9: worked case
    drive(16'h0B54, 16'h0B1B);
    chk("R9", 64'(p12), 64'h7DCDDC);

    // R7: powers of two
    for (int k = 0; k < 16; k++) begin
      y = 16'($urandom);
      drive(16'(1) << k, y);
      chk("R7 N16", 64'(p16), 64'(b16) << k);
      check_all("R7");
    end

    // R6: operand swap
    for (int i = 0; i < 20; i++) begin
      x = 16'($urandom);
      y = 16'($urandom);
      drive(x, y);
      s12 = p12;
      s16 = p16;
      drive(y, x);
      chk("R6 N12", 64'(p12), 64'(s12));
      chk("R6 N16", 64'(p16), 64'(s16));
    end

    // R5: uncompressed low columns
    for (int i = 0; i < 20; i++) begin
      x = 16'($urandom);
      y = 16'($urandom);
      drive(x, y);
      chk("R5", 64'(p12[1:0]),
          64'({(a12[1] & b12[0]) ^ (a12[0] & b12[1]), a12[0] & b12[0]}));
    end

    // R1 and R8: random operands on all four widths
    for (int i = 0; i < 400; i++) begin
      x = 16'($urandom);
      y = 16'($urandom);
      drive(x, y);
      check_all("R1/R8");
    end

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule